// File: doc/BRIEF.md
# Programmable RGB Panel Timing Generator

The block drives a parallel RGB panel. It produces a divided pixel clock and a one-clock pixel enable. It also produces active-low horizontal and vertical sync, a data-enable strobe, and the x/y coordinates of the pixel currently being shown. Each axis is described by five values, all counted from the start of the line or frame:

- the total length of the axis;
- the position where the active area begins;
- the position where sync asserts;
- the position where sync releases;
- the number of active pixels or lines.

Software writes these values into a staging copy. The staging copy becomes the working copy at each frame boundary, so the timing never changes part-way through a frame.

Software can request a frame swap. The request waits until the next frame boundary. There a consistency check runs on the staged values. The swap is acknowledged only if, on both axes, the total length is strictly greater than the active start plus the active size. If the check fails, an error flag is raised instead. While the working timing is inconsistent, data-enable stays low.

Pixels arrive on an 18-bit valid/ready stream, packed as red in bits 17:12, green in bits 11:6 and blue in bits 5:0. The panel cannot be stalled, so the rules are these:

- `pix_ready` is offered for exactly one clock at the start of each active pixel period.
- The source must present its word in that clock.
- If `pix_valid` is low at that moment, a black (all-zero) pixel is shown.
- A word presented while `pix_ready` is low is not taken.

Top module: `rgb_panel_timing`

## Requirements
- R1: `pclk_en` is high for one clock in every DIV clocks. The first clock of each pixel period is phase 0, and `pclk_en` marks phase DIV-1. With `pclk_pol`=0, `pclk` is high during the last DIV/2 phases and low otherwise; with `pclk_pol`=1 it is inverted. All timing outputs therefore change at phase 0, well before the panel's sampling edge.
- R2: The horizontal position advances once per pixel period and runs from 0 to CYCLE-1. The vertical position advances when the horizontal position wraps, and runs from 0 to its own CYCLE-1.
- R3: `hsync_n` is low exactly when the horizontal position p satisfies SYNC0 <= p < SYNC1. `vsync_n` follows the same rule using the vertical position.
- R4: `de` is high when both of these hold and the working timing is consistent: OFFSET <= h < OFFSET+SIZE horizontally, and OFFSET <= v < OFFSET+SIZE vertically. While `de` is high, `pos_x` = h-OFFSET and `pos_y` = v-OFFSET. Both are 0 while `de` is low.
- R5: `pix_ready` is high in phase 0 of every pixel period with `de` high. From the next clock, `pix_out` holds the word taken in that clock, or zero if `pix_valid` was low. `pix_out` is zero whenever `de` is low.
- R6: A configuration write (`cfg_vert`=0 selects horizontal, 1 selects vertical) changes only the staging copy. The staging copy becomes the working timing in the clock after the frame's last pixel enable, not earlier.
- R7: A swap is accepted when the staged values satisfy CYCLE > OFFSET+SIZE on both axes. Acceptance pulses `swap_ack` for one clock right after the frame boundary and clears `cfg_err`.
- R8: A swap checked against inconsistent staged values gives no `swap_ack` and sets `cfg_err`. `de` stays low for the whole frame that uses that timing.
- R9: After reset, the working and staging timing equal the parameter defaults and both counters are 0. `swap_ack`, `cfg_err` and `pix_out` are low. The default horizontal timing is porch 38, sync 10, back porch 10, 240 active, total = sum+1. The default vertical timing is porch 8, sync 4, back porch 4, 320 active, total = sum+1.
- R10: A swap request is held until the next frame boundary. Any number of requests within one frame yield at most one acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pclk_pol | input | 1 | Pixel clock polarity: 0 = panel samples on rising edge |
| cfg_wr | input | 1 | Write strobe for the staging timing of one axis |
| cfg_vert | input | 1 | Axis select for the write: 0 horizontal, 1 vertical |
| cfg_cycle | input | 12 | Total positions per line/frame |
| cfg_offset | input | 12 | Position where the active area begins |
| cfg_sync0 | input | 12 | Position where sync asserts |
| cfg_sync1 | input | 12 | Position where sync releases |
| cfg_size | input | 12 | Active pixels/lines |
| swap_req | input | 1 | Frame swap request pulse |
| swap_ack | output | 1 | One-clock acknowledge of an accepted swap |
| cfg_err | output | 1 | Set by a refused swap, cleared by an accepted one |
| pix_valid | input | 1 | Pixel stream word valid |
| pix_ready | output | 1 | Pixel stream accept, one clock per active pixel |
| pix_in | input | 18 | Pixel word R[17:12] G[11:6] B[5:0] |
| pclk | output | 1 | Divided pixel clock to the panel |
| pclk_en | output | 1 | One-clock pixel enable, last clock of a pixel period |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| de | output | 1 | Data enable |
| pix_out | output | 18 | Pixel to the panel, zero outside the active area |
| pos_x | output | 12 | Active-area column |
| pos_y | output | 12 | Active-area row |

## Verification
The bench targets the following corner cases and the faults each would expose:

- **Reprogramming mid-frame.** A configuration is written part-way through a frame and must not take effect until the boundary. A design that loads it at once would move sync and `de` within the running frame.
- **Equality case.** The total length is set equal to offset plus size. A design that uses >= instead of > would acknowledge this swap and keep `de` running.
- **Two requests in one frame.** Two swap requests are issued before the same boundary. A design without a proper pending flag would acknowledge twice or lose the request.
- **Pixel underrun and polarity.** Underrun pixels and the inverted clock polarity are mixed into the stream. A wrongly phased ready would shift pixels by a period, and a wrongly phased clock would show up in the cycle-by-cycle comparison.

// File: rtl/rgbt_pkg.sv
package rgbt_pkg;
  localparam int unsigned CW = 12;

  typedef logic [CW-1:0] pos_t;

  typedef struct packed {
    pos_t cycle;
    pos_t offset;
    pos_t sync0;
    pos_t sync1;
    pos_t size;
  } tim_t;

  // Consistency rule: active window must end strictly inside the cycle.
  function automatic logic tim_ok(input tim_t t);
    logic [CW+1:0] lim;
    lim = {2'b00, t.offset} + {2'b00, t.size};
    return {2'b00, t.cycle} > lim;
  endfunction

  function automatic tim_t tim_make(input int unsigned fp, input int unsigned sw,
                                    input int unsigned bp, input int unsigned act);
    tim_t t;
    t.sync0  = pos_t'(fp);
    t.sync1  = pos_t'(fp + sw);
    t.offset = pos_t'(fp + sw + bp);
    t.size   = pos_t'(act);
    t.cycle  = pos_t'(fp + sw + bp + act + 1);
    return t;
  endfunction
endpackage

// File: rtl/rgbt_pclk_div.sv
module rgbt_pclk_div #(
  parameter int unsigned DIV = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pol,
  output logic first,
  output logic tick,
  output logic pclk
);
  // DIV must be at least 3 so data settles a full clock before the sampling edge.
  localparam int unsigned PW      = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int unsigned HI_FROM = DIV - DIV / 2;

  logic [PW-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         phase <= '0;
    else if (phase == PW'(DIV - 1))     phase <= '0;
    else                                phase <= phase + 1'b1;
  end

  assign first = (phase == '0);
  assign tick  = (phase == PW'(DIV - 1));
  assign pclk  = pol ^ (phase >= PW'(HI_FROM));

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= PW'(DIV - 1)); // R1
  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R1
endmodule

// File: rtl/rgbt_axis.sv
module rgbt_axis
  import rgbt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  tim_t cfg,
  output pos_t cnt,
  output logic last,
  output logic sync_on,
  output logic in_act
);
  logic [CW:0] nxt;
  logic [CW:0] act_end;

  assign nxt     = {1'b0, cnt} + 1'b1;
  assign act_end = {1'b0, cfg.offset} + {1'b0, cfg.size};
  assign last    = nxt >= {1'b0, cfg.cycle};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (step) cnt <= last ? '0 : nxt[CW-1:0];
  end

  assign sync_on = (cnt >= cfg.sync0) && (cnt < cfg.sync1);
  assign in_act  = (cnt >= cfg.offset) && ({1'b0, cnt} < act_end);

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(cnt)); // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !last) |=> (cnt == pos_t'($past(cnt) + 1'b1))); // R2
endmodule

// File: rtl/rgbt_cfg_bank.sv
module rgbt_cfg_bank
  import rgbt_pkg::*;
#(
  parameter tim_t H_DEF = '0,
  parameter tim_t V_DEF = '0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic sel_v,
  input  tim_t wr_tim,
  input  logic frame_end,
  input  logic swap_req,
  output tim_t act_h,
  output tim_t act_v,
  output logic act_ok,
  output logic swap_ack,
  output logic cfg_err
);
  tim_t stg_h, stg_v;
  logic pend;
  logic stg_ok;

  assign stg_ok = tim_ok(stg_h) && tim_ok(stg_v);
  assign act_ok = tim_ok(act_h) && tim_ok(act_v);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_h    <= H_DEF;
      stg_v    <= V_DEF;
      act_h    <= H_DEF;
      act_v    <= V_DEF;
      pend     <= 1'b0;
      swap_ack <= 1'b0;
      cfg_err  <= 1'b0;
    end else begin
      swap_ack <= 1'b0;
      if (wr) begin
        if (sel_v) stg_v <= wr_tim;
        else       stg_h <= wr_tim;
      end
      if (frame_end) begin
        act_h <= stg_h;
        act_v <= stg_v;
        pend  <= 1'b0;
        if (pend || swap_req) begin
          if (stg_ok) begin
            swap_ack <= 1'b1;
            cfg_err  <= 1'b0;
          end else begin
            cfg_err  <= 1'b1;
          end
        end
      end else if (swap_req) begin
        pend <= 1'b1;
      end
    end
  end

  AST_ACK_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    swap_ack |-> $past(frame_end)); // R7
  AST_ACK_CLEARS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    swap_ack |-> !cfg_err); // R7
  AST_ERR_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_err) |-> $past(frame_end)); // R8
  AST_WORKING_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> ($stable(act_h) && $stable(act_v))); // R6
endmodule

// File: rtl/rgb_panel_timing.sv
module rgb_panel_timing
  import rgbt_pkg::*;
#(
  parameter int unsigned DIV   = 3,
  parameter int unsigned CDW   = 6,
  parameter int unsigned H_FP  = 38,
  parameter int unsigned H_SW  = 10,
  parameter int unsigned H_BP  = 10,
  parameter int unsigned H_ACT = 240,
  parameter int unsigned V_FP  = 8,
  parameter int unsigned V_SW  = 4,
  parameter int unsigned V_BP  = 4,
  parameter int unsigned V_ACT = 320
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pclk_pol,
  input  logic              cfg_wr,
  input  logic              cfg_vert,
  input  logic [CW-1:0]     cfg_cycle,
  input  logic [CW-1:0]     cfg_offset,
  input  logic [CW-1:0]     cfg_sync0,
  input  logic [CW-1:0]     cfg_sync1,
  input  logic [CW-1:0]     cfg_size,
  input  logic              swap_req,
  output logic              swap_ack,
  output logic              cfg_err,
  input  logic              pix_valid,
  output logic              pix_ready,
  input  logic [3*CDW-1:0]  pix_in,
  output logic              pclk,
  output logic              pclk_en,
  output logic              hsync_n,
  output logic              vsync_n,
  output logic              de,
  output logic [3*CDW-1:0]  pix_out,
  output logic [CW-1:0]     pos_x,
  output logic [CW-1:0]     pos_y
);
  localparam int unsigned PXW   = 3 * CDW;
  localparam tim_t        H_DEF = tim_make(H_FP, H_SW, H_BP, H_ACT);
  localparam tim_t        V_DEF = tim_make(V_FP, V_SW, V_BP, V_ACT);

  logic tick, first;
  logic frame_end;
  logic act_ok;
  tim_t act_h, act_v, wr_tim;
  tim_t ax_cfg  [2];
  logic ax_step [2];
  pos_t ax_cnt  [2];
  logic ax_last [2];
  logic ax_sync [2];
  logic ax_in   [2];
  logic [PXW-1:0] pix_hold;

  assign wr_tim = '{cycle: cfg_cycle, offset: cfg_offset, sync0: cfg_sync0,
                    sync1: cfg_sync1, size: cfg_size};

  rgbt_pclk_div #(.DIV(DIV)) i_div (
    .clk(clk), .rst_n(rst_n), .pol(pclk_pol),
    .first(first), .tick(tick), .pclk(pclk)
  );

  rgbt_cfg_bank #(.H_DEF(H_DEF), .V_DEF(V_DEF)) i_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .sel_v(cfg_vert), .wr_tim(wr_tim),
    .frame_end(frame_end), .swap_req(swap_req),
    .act_h(act_h), .act_v(act_v), .act_ok(act_ok),
    .swap_ack(swap_ack), .cfg_err(cfg_err)
  );

  assign ax_cfg[0]  = act_h;
  assign ax_cfg[1]  = act_v;
  assign ax_step[0] = tick;
  assign ax_step[1] = tick && ax_last[0];

  // Axis 0 is horizontal, axis 1 vertical; the vertical one steps on line wrap.
  for (genvar a = 0; a < 2; a++) begin : g_axis
    rgbt_axis i_axis (
      .clk(clk), .rst_n(rst_n), .step(ax_step[a]), .cfg(ax_cfg[a]),
      .cnt(ax_cnt[a]), .last(ax_last[a]), .sync_on(ax_sync[a]), .in_act(ax_in[a])
    );
  end

  assign frame_end = tick && ax_last[0] && ax_last[1];
  assign pclk_en   = tick;
  assign hsync_n   = !ax_sync[0];
  assign vsync_n   = !ax_sync[1];
  assign de        = act_ok && ax_in[0] && ax_in[1];
  assign pos_x     = de ? (ax_cnt[0] - act_h.offset) : '0;
  assign pos_y     = de ? (ax_cnt[1] - act_v.offset) : '0;
  assign pix_ready = de && first;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pix_hold <= '0;
    else if (pix_ready) pix_hold <= pix_valid ? pix_in : '0;
  end

  assign pix_out = de ? pix_hold : '0;

  AST_READY_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready |=> !pix_ready); // R5
  AST_X_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (pos_x < act_h.size)); // R4
  AST_Y_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (pos_y < act_v.size)); // R4
endmodule

// File: tb/test_rgb_panel_timing.sv
module test_rgb_panel_timing;
  localparam int DIV = 3;
  localparam int CW  = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pclk_pol = 1'b0;
  logic cfg_wr = 1'b0, cfg_vert = 1'b0;
  logic [CW-1:0] cfg_cycle = '0, cfg_offset = '0, cfg_sync0 = '0, cfg_sync1 = '0, cfg_size = '0;
  logic swap_req = 1'b0;
  logic pix_valid = 1'b0;
  logic [17:0] pix_in = '0;
  logic swap_ack, cfg_err, pix_ready, pclk, pclk_en, hsync_n, vsync_n, de;
  logic [17:0] pix_out;
  logic [CW-1:0] pos_x, pos_y;

  int n_chk = 0, n_fail = 0;
  int ack_cnt = 0, de_cnt = 0, cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rgb_panel_timing #(.DIV(DIV), .H_FP(2), .H_SW(2), .H_BP(2), .H_ACT(6),
                     .V_FP(1), .V_SW(1), .V_BP(1), .V_ACT(4)) i_rgb_panel_timing (
    .clk(clk), .rst_n(rst_n), .pclk_pol(pclk_pol), .cfg_wr(cfg_wr), .cfg_vert(cfg_vert),
    .cfg_cycle(cfg_cycle), .cfg_offset(cfg_offset), .cfg_sync0(cfg_sync0),
    .cfg_sync1(cfg_sync1), .cfg_size(cfg_size), .swap_req(swap_req),
    .swap_ack(swap_ack), .cfg_err(cfg_err), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_in(pix_in), .pclk(pclk), .pclk_en(pclk_en), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .de(de), .pix_out(pix_out), .pos_x(pos_x), .pos_y(pos_y)
  );

  // Reference model: index 0 horizontal, 1 vertical; fields cycle,offset,sync0,sync1,size.
  int a [2][5];
  int s [2][5];
  int ph, h, v, hold;
  bit pend, err, ack;

  function automatic bit cfg_good(input int c [2][5]);
    return (c[0][0] > c[0][1] + c[0][4]) && (c[1][0] > c[1][1] + c[1][4]);
  endfunction

  function automatic bit m_de();
    return cfg_good(a) && h >= a[0][1] && h < a[0][1] + a[0][4]
                       && v >= a[1][1] && v < a[1][1] + a[1][4];
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      a = '{'{13, 6, 2, 4, 6}, '{8, 3, 1, 2, 4}};
      s = a;
      ph = 0; h = 0; v = 0; hold = 0; pend = 0; err = 0; ack = 0;
    end else begin
      bit tk, hl, vl, fe, rdy;
      tk  = (ph == DIV - 1);
      hl  = (h + 1 >= a[0][0]);
      vl  = (v + 1 >= a[1][0]);
      fe  = tk && hl && vl;
      rdy = m_de() && ph == 0;
      if (rdy) hold = pix_valid ? int'(pix_in) : 0;
      ack = 0;
      if (fe) begin
        if (pend || swap_req) begin
          if (cfg_good(s)) begin ack = 1; err = 0; end
          else err = 1;
        end
        pend = 0;
        a = s;
      end else if (swap_req) pend = 1;
      if (cfg_wr) begin
        s[cfg_vert][0] = int'(cfg_cycle);  s[cfg_vert][1] = int'(cfg_offset);
        s[cfg_vert][2] = int'(cfg_sync0);  s[cfg_vert][3] = int'(cfg_sync1);
        s[cfg_vert][4] = int'(cfg_size);
      end
      if (tk) begin
        if (hl) v = vl ? 0 : v + 1;
        h = hl ? 0 : h + 1;
      end
      ph = tk ? 0 : ph + 1;
    end
  end

  // Per-clock comparison away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit e_de;
      string dtag;
      e_de = m_de();
      dtag = !cfg_good(a) ? "R8" : (s != a ? "R6" : "R4");
      chk("R1 pclk_en", pclk_en, ph == DIV - 1);
      chk("R1 pclk", pclk, pclk_pol ^ (ph >= DIV - DIV / 2));
      chk("R3 hsync_n", hsync_n, !(h >= a[0][2] && h < a[0][3]));
      chk("R3 vsync_n", vsync_n, !(v >= a[1][2] && v < a[1][3]));
      chk({dtag, " de"}, de, e_de);
      chk("R2 pos_x", pos_x, e_de ? h - a[0][1] : 0);
      chk("R2 pos_y", pos_y, e_de ? v - a[1][1] : 0);
      chk("R5 pix_ready", pix_ready, e_de && ph == 0);
      chk("R5 pix_out", pix_out, e_de ? hold : 0);
      chk("R7 swap_ack", swap_ack, ack);
      chk("R8 cfg_err", cfg_err, err);
      if (swap_ack) ack_cnt++;
      if (de) de_cnt++;
    end
  end

  // Pixel source: counting data with periodic underruns.
  always @(posedge clk) begin
    #1;
    pix_in    <= pix_in + 18'd4099;
    pix_valid <= (cyc % 7) != 3;
    cyc++;
  end

  task automatic wr_axis(input bit vert, input int fp, input int sw, input int bp,
                         input int act, input int extra);
    @(posedge clk); #1;
    cfg_wr = 1; cfg_vert = vert;
    cfg_sync0 = CW'(fp); cfg_sync1 = CW'(fp + sw); cfg_offset = CW'(fp + sw + bp);
    cfg_size = CW'(act); cfg_cycle = CW'(fp + sw + bp + act + extra);
    @(posedge clk); #1;
    cfg_wr = 0;
  endtask

  task automatic pulse_swap();
    @(posedge clk); #1; swap_req = 1;
    @(posedge clk); #1; swap_req = 0;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R9: reset state with defaults
    chk("R9 cfg_err", cfg_err, 0);
    chk("R9 swap_ack", swap_ack, 0);
    chk("R9 pix_out", pix_out, 0);
    chk("R9 hsync_n", hsync_n, 1);
    wait_clk(700);
    pclk_pol = 1;                      // R1 inverted polarity stretch
    wait_clk(400);
    pclk_pol = 0;
    wait_clk(50);
    // R6: new timing written mid-frame, two swap requests in one frame (R10)
    wr_axis(0, 1, 3, 1, 5, 1);
    wr_axis(1, 2, 1, 1, 3, 1);
    ack_cnt = 0;
    pulse_swap();
    wait_clk(20);
    pulse_swap();
    wait_clk(700);
    chk("R10 one ack for two requests", ack_cnt, 1);
    chk("R7 err clear after accept", cfg_err, 0);
    // R8: total equal to offset+size must be refused
    wr_axis(0, 1, 3, 1, 5, 0);
    pulse_swap();
    wait_clk(400);
    de_cnt = 0;
    wait_clk(400);
    chk("R8 err set", cfg_err, 1);
    chk("R8 no ack", ack_cnt, 1);
    chk("R8 de held low", de_cnt, 0);
    // R7: restore consistent timing and swap again
    wr_axis(0, 1, 3, 1, 5, 1);
    pulse_swap();
    wait_clk(400);
    de_cnt = 0;
    wait_clk(400);
    chk("R7 second ack", ack_cnt, 2);
    chk("R7 err cleared", cfg_err, 0);
    chk("R4 de resumed", int'(de_cnt > 0), 1);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    done = 1;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule